// File: doc/BRIEF.md
# Shared Receive Silo with Alarm Threshold

The block gathers completed characters from several serial receivers into a single shared first-in first-out store, the silo. Each receiver raises a one-cycle completion strobe together with its character, a framing-error bit, a parity-error bit and a break indication. The block holds each strobe in a per-line register and moves one held character per cycle into the silo. Every stored entry is tagged with the number of the line it came from and with its error flags.

The host reads a 16-bit receive word. Each pop strobe removes the oldest entry. A word with its valid bit clear means the silo is empty, so software drains the silo by reading until valid drops.

A receive interrupt either follows any stored character or, when the alarm mode is selected, waits until a quarter of the silo is occupied. A global interrupt enable gates it in both modes. A character that arrives while the silo is full is lost, and the next entry stored afterwards carries an overrun mark.

Top module: `rx_silo`

## Requirements
- R1: After reset the silo is empty, `rbuf_word` is 0 and `rx_irq` is low.
- R2: A valid receive word has bit 15 = valid, bit 14 = overrun, bit 13 = framing error, bit 12 = parity error, bit 11 = 0, bits 10:8 = source line number and bits 7:0 = character; an empty silo reads as 16'h0000.
- R3: Entries leave in arrival order. A pop strobe while the word is valid removes the head entry, and the next entry appears after that clock edge. A pop while the silo is empty changes nothing.
- R4: A strobe on an idle line that is sampled at clock edge k reaches the silo at edge k+1. With an empty silo it therefore shows on `rbuf_word` right after edge k+1.
- R5: Lines that strobe in the same cycle are stored one per cycle in consecutive cycles, in ascending order of line number. A line that strobes again before its held character is stored replaces that character.
- R6: A character flagged as a break is stored as character 8'h00 with the framing-error bit set.
- R7: The silo holds at most 64 entries. A character that reaches the silo while 64 entries are held, judged before that edge's pop, is discarded.
- R8: After one or more characters are discarded, the next entry that is stored has the overrun bit set. Later entries have it clear until another discard.
- R9: With `alarm_en` low and `rx_int_en` high, `rx_irq` is high exactly while at least one entry is held.
- R10: With `alarm_en` high and `rx_int_en` high, `rx_irq` is high exactly while at least 16 entries are held.
- R11: With `rx_int_en` low, `rx_irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_done | input | 8 | Per-line character-complete strobe |
| line_data | input | 64 | Per-line character, line i in bits 8i+7:8i |
| line_ferr | input | 8 | Per-line framing error |
| line_perr | input | 8 | Per-line parity error |
| line_brk | input | 8 | Per-line break received |
| alarm_en | input | 1 | Defer the interrupt until the alarm threshold |
| rx_int_en | input | 1 | Receive interrupt enable |
| rbuf_pop | input | 1 | Remove the head entry at this clock edge |
| rbuf_word | output | 16 | Head entry, or zero when empty |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A strobe is held for one edge and written to the silo at the next edge. The receive word and the interrupt are combinational from the silo state, so both are due right after that second edge, and a pop takes effect at its own edge. The bench drives inputs and samples outputs on the falling edge. After each rising edge it steps a reference model through the same order of events: pop the head, store the lowest held line with the full test made against the pre-edge occupancy, then latch the new strobes. The outputs are then compared with the model once every cycle.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;
    localparam int WORD_W    = 16;
    localparam int VALID_BIT = 15;
    localparam int OVR_BIT   = 14;
    localparam int FERR_BIT  = 13;
    localparam int PERR_BIT  = 12;
    localparam int LINE_LSB  = 8;
endpackage

// File: rtl/rx_capture.sv
module rx_capture #(
    parameter int NUM_LINES = 8,
    parameter int CHAR_W    = 8,
    parameter int LINE_W    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_LINES-1:0]          done,
    input  logic [NUM_LINES*CHAR_W-1:0]   chars,
    input  logic [NUM_LINES-1:0]          ferr,
    input  logic [NUM_LINES-1:0]          perr,
    input  logic [NUM_LINES-1:0]          brk,
    output logic                          wr_valid,
    output logic [LINE_W-1:0]             wr_line,
    output logic [CHAR_W-1:0]             wr_char,
    output logic                          wr_ferr,
    output logic                          wr_perr
);
    typedef struct packed {
        logic [NUM_LINES-1:0]             pend;
        logic [NUM_LINES-1:0]             fe;
        logic [NUM_LINES-1:0]             pe;
        logic [NUM_LINES-1:0][CHAR_W-1:0] ch;
    } cap_t;

    cap_t s_d, s_q;
    logic [LINE_W-1:0]    sel;
    logic [NUM_LINES-1:0] grant;

    always_comb begin
        s_d = s_q;
        sel = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (s_q.pend[i]) sel = LINE_W'(i);
        end
        grant = (s_q.pend != '0) ? (NUM_LINES'(1) << sel) : '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            s_d.pend[i] = (s_q.pend[i] & ~grant[i]) | done[i];
            if (done[i]) begin
                s_d.ch[i] = brk[i] ? '0 : chars[i*CHAR_W +: CHAR_W];
                s_d.fe[i] = ferr[i] | brk[i];
                s_d.pe[i] = perr[i];
            end
        end
        wr_valid = s_q.pend != '0;
        wr_line  = sel;
        wr_char  = s_q.ch[sel];
        wr_ferr  = s_q.fe[sel];
        wr_perr  = s_q.pe[sel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: a strobe is held and offered to the silo at the following edge
    a_r4_strobe_held: assert property (@(posedge clk) disable iff (!rst_n)
        (|done) |=> wr_valid);

    // R5: with no new strobes, exactly one held line leaves per cycle
    a_r5_one_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !(|done)) |=>
        ($countones(s_q.pend) + 1 == $past($countones(s_q.pend))));
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
    parameter int DEPTH   = 64,
    parameter int ENTRY_W = 14,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [ENTRY_W-1:0] push_data,
    input  logic               pop,
    output logic [ENTRY_W-1:0] head,
    output logic [CNT_W-1:0]   count,
    output logic               full
);
    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
    } fifo_t;

    fifo_t s_d, s_q;
    logic  wr_ok, rd_ok;
    logic [ENTRY_W-1:0] mem [DEPTH];

    always_comb begin
        s_d   = s_q;
        full  = s_q.cnt == CNT_W'(DEPTH);
        wr_ok = push && !full;
        rd_ok = pop && (s_q.cnt != '0);
        if (wr_ok) s_d.wptr = s_q.wptr + 1'b1;
        if (rd_ok) s_d.rptr = s_q.rptr + 1'b1;
        s_d.cnt = s_q.cnt + CNT_W'(wr_ok) - CNT_W'(rd_ok);
        head  = mem[s_q.rptr];
        count = s_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[s_q.wptr] <= push_data;
    end

    // R7: occupancy never passes the silo depth
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R3: occupancy moves by at most one entry per edge
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (count <= $past(count) + 1) && (count + 1 >= $past(count)));

    // R3: a pop of an empty silo leaves it empty when nothing is offered
    a_r3_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !push) |=> (count == '0));
endmodule

// File: rtl/rx_irq_gen.sv
module rx_irq_gen #(
    parameter int CNT_W       = 7,
    parameter int ALARM_LEVEL = 16
) (
    input  logic [CNT_W-1:0] count,
    input  logic             alarm_en,
    input  logic             int_en,
    output logic             irq
);
    logic reached;

    always_comb begin
        reached = alarm_en ? (count >= CNT_W'(ALARM_LEVEL)) : (count != '0);
        irq     = int_en && reached;
    end
endmodule

// File: rtl/rx_silo.sv
module rx_silo #(
    parameter int NUM_LINES   = 8,
    parameter int CHAR_W      = 8,
    parameter int DEPTH       = 64,
    parameter int ALARM_LEVEL = DEPTH / 4,
    localparam int LINE_W     = $clog2(NUM_LINES),
    localparam int ENTRY_W    = 3 + LINE_W + CHAR_W,
    localparam int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        line_done,
    input  logic [NUM_LINES*CHAR_W-1:0] line_data,
    input  logic [NUM_LINES-1:0]        line_ferr,
    input  logic [NUM_LINES-1:0]        line_perr,
    input  logic [NUM_LINES-1:0]        line_brk,
    input  logic                        alarm_en,
    input  logic                        rx_int_en,
    input  logic                        rbuf_pop,
    output logic [15:0]                 rbuf_word,
    output logic                        rx_irq
);
    import rx_silo_pkg::*;

    typedef struct packed {
        logic ovr;
    } top_t;

    top_t s_d, s_q;

    logic               wr_valid, wr_ferr, wr_perr, full;
    logic [LINE_W-1:0]  wr_line;
    logic [CHAR_W-1:0]  wr_char;
    logic [ENTRY_W-1:0] push_data, head;
    logic [CNT_W-1:0]   count;
    logic               drop;

    rx_capture #(.NUM_LINES(NUM_LINES), .CHAR_W(CHAR_W), .LINE_W(LINE_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .done(line_done), .chars(line_data),
        .ferr(line_ferr), .perr(line_perr), .brk(line_brk),
        .wr_valid(wr_valid), .wr_line(wr_line), .wr_char(wr_char),
        .wr_ferr(wr_ferr), .wr_perr(wr_perr)
    );

    rx_fifo #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(wr_valid), .push_data(push_data),
        .pop(rbuf_pop), .head(head), .count(count), .full(full)
    );

    rx_irq_gen #(.CNT_W(CNT_W), .ALARM_LEVEL(ALARM_LEVEL)) u_irq (
        .count(count), .alarm_en(alarm_en), .int_en(rx_int_en), .irq(rx_irq)
    );

    always_comb begin
        s_d       = s_q;
        push_data = {s_q.ovr, wr_ferr, wr_perr, wr_line, wr_char};
        drop      = wr_valid && full;
        if (drop)          s_d.ovr = 1'b1;
        else if (wr_valid) s_d.ovr = 1'b0;

        rbuf_word = '0;
        if (count != '0) begin
            rbuf_word[VALID_BIT]              = 1'b1;
            rbuf_word[OVR_BIT]                = head[ENTRY_W-1];
            rbuf_word[FERR_BIT]               = head[ENTRY_W-2];
            rbuf_word[PERR_BIT]               = head[ENTRY_W-3];
            rbuf_word[LINE_LSB +: LINE_W]     = head[CHAR_W +: LINE_W];
            rbuf_word[CHAR_W-1:0]             = head[CHAR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8: a discard arms the overrun mark for the next stored entry
    a_r8_mark_armed: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> s_q.ovr);

    // R2: an empty silo reads as all zeros
    a_r2_empty_word: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> (rbuf_word == 16'h0000));

    // R9: immediate mode raises the request for any held entry
    a_r9_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_en && rx_int_en && count != '0) |-> rx_irq);

    // R10: alarm mode stays quiet below the threshold
    a_r10_alarm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_en && count < CNT_W'(ALARM_LEVEL)) |-> !rx_irq);

    // R11: the enable masks the request
    a_r11_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_int_en |-> !rx_irq);
endmodule

// File: tb/rx_silo_test.sv
module rx_silo_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  line_done = '0, line_ferr = '0, line_perr = '0, line_brk = '0;
    logic [63:0] line_data = '0;
    logic        alarm_en = 1'b0, rx_int_en = 1'b0, rbuf_pop = 1'b0;
    logic [15:0] rbuf_word;
    logic        rx_irq;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rx_silo uut (
        .clk(clk), .rst_n(rst_n), .line_done(line_done), .line_data(line_data),
        .line_ferr(line_ferr), .line_perr(line_perr), .line_brk(line_brk),
        .alarm_en(alarm_en), .rx_int_en(rx_int_en), .rbuf_pop(rbuf_pop),
        .rbuf_word(rbuf_word), .rx_irq(rx_irq)
    );

    // reference model
    bit [15:0] q[$];
    bit        pend[8], pfe[8], ppe[8];
    bit [7:0]  pch[8];
    bit        movr;

    function automatic bit [15:0] mk_word(int line, bit [7:0] ch, bit fe, bit pe, bit ov);
        return {1'b1, ov, fe, pe, 1'b0, 3'(line), ch};
    endfunction

    function automatic bit [15:0] exp_word();
        return (q.size() > 0) ? q[0] : 16'h0000;
    endfunction

    function automatic bit exp_irq();
        if (!rx_int_en) return 1'b0;
        return alarm_en ? (q.size() >= 16) : (q.size() > 0);
    endfunction

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic model_edge();
        int pre = q.size();
        int sel = -1;
        if (rbuf_pop && pre > 0) void'(q.pop_front());
        for (int i = 7; i >= 0; i--) if (pend[i]) sel = i;
        if (sel >= 0) begin
            pend[sel] = 0;
            if (pre < 64) begin
                q.push_back(mk_word(sel, pch[sel], pfe[sel], ppe[sel], movr));
                movr = 0;
            end else movr = 1;
        end
        for (int i = 0; i < 8; i++) begin
            if (line_done[i]) begin
                pend[i] = 1;
                pch[i]  = line_brk[i] ? 8'h00 : line_data[i*8 +: 8];
                pfe[i]  = line_ferr[i] | line_brk[i];
                ppe[i]  = line_perr[i];
            end
        end
    endtask

    // called on a falling edge; drives, clocks, checks on the next falling edge
    task automatic step(bit [7:0] dn, bit [63:0] dat, bit [7:0] fe, bit [7:0] pe,
                        bit [7:0] bk, bit pop, string tag);
        string itag;
        line_done = dn; line_data = dat; line_ferr = fe; line_perr = pe;
        line_brk = bk; rbuf_pop = pop;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        line_done = '0; rbuf_pop = 1'b0;
        chk(tag, rbuf_word, exp_word());
        itag = !rx_int_en ? "R11" : (alarm_en ? "R10" : "R9");
        chk(itag, rx_irq, exp_irq());
    endtask

    task automatic idle(int n, bit pop, string tag);
        for (int i = 0; i < n; i++) step('0, '0, '0, '0, '0, pop, tag);
    endtask

    task automatic drain(string tag);
        while (q.size() > 0 || pend.sum() with (int'(item)) > 0)
            step('0, '0, '0, '0, '0, 1'b1, tag);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int ovr_seen;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rx_int_en = 1'b1;
        // R1: reset state
        chk("R1", rbuf_word, 16'h0000);
        chk("R1", rx_irq, 0);

        // R3: pop on empty silo has no effect
        step('0, '0, '0, '0, '0, 1'b1, "R3");
        chk("R3", rbuf_word, 16'h0000);

        // R4: strobe on line 4 with parity error, visible one edge later
        step(8'h10, 64'hA5 << 32, '0, 8'h10, '0, 1'b0, "R4");
        chk("R4", rbuf_word, 16'h0000);
        idle(1, 0, "R4");
        chk("R2", rbuf_word, 16'h94A5);
        drain("R3");

        // R6: break on line 6 stores NUL with framing error
        step(8'h40, 64'h55 << 48, '0, '0, 8'h40, 1'b0, "R6");
        idle(1, 0, "R6");
        chk("R6", rbuf_word, 16'hA600);
        drain("R6");

        // R5: lines 5 and 2 together, then line 2 replaced before storage
        step(8'h24, (64'h11 << 16) | (64'h22 << 40), '0, '0, '0, 1'b0, "R5");
        idle(1, 0, "R5");
        chk("R5", rbuf_word, 16'h8211);
        idle(1, 1, "R5");
        chk("R5", rbuf_word, 16'h8522);
        drain("R3");
        step(8'h09, (64'h31) | (64'h33 << 24), '0, '0, '0, 1'b0, "R5");
        step(8'h08, (64'h44 << 24), '0, '0, '0, 1'b0, "R5");
        idle(2, 0, "R5");
        chk("R5", rbuf_word, 16'h8031);
        idle(1, 1, "R5");
        chk("R5", rbuf_word, 16'h8344);
        drain("R3");

        // R10: alarm threshold
        alarm_en = 1'b1;
        for (int i = 0; i < 17; i++) step(8'h01, 64'(i), '0, '0, '0, 1'b0, "R10");
        idle(1, 0, "R10");
        chk("R10", rx_irq, 1);
        // R11: mask
        rx_int_en = 1'b0;
        idle(1, 0, "R11");
        chk("R11", rx_irq, 0);
        rx_int_en = 1'b1;
        drain("R3");
        alarm_en = 1'b0;

        // R7 / R8: overflow on line 3 then one entry from line 1
        for (int i = 0; i < 70; i++) step(8'h08, 64'(i) << 24, '0, '0, '0, 1'b0, "R7");
        idle(1, 0, "R7");
        step(8'h02, 64'h7E << 8, '0, '0, '0, 1'b1, "R8");
        idle(2, 0, "R8");
        ovr_seen = 0;
        while (rbuf_word[15]) begin
            if (rbuf_word[14]) ovr_seen++;
            step('0, '0, '0, '0, '0, 1'b1, "R8");
        end
        chk("R8", ovr_seen, 1);

        // random traffic, all requirements by model
        for (int n = 0; n < 4000; n++) begin
            bit [7:0] dn;
            if (n % 250 == 0) begin
                alarm_en  = $urandom_range(0, 1);
                rx_int_en = $urandom_range(0, 3) != 0;
            end
            dn = ((n / 500) % 2 == 0) ? 8'($urandom & $urandom & $urandom)
                                      : 8'($urandom & $urandom & $urandom & $urandom);
            step(dn, {$urandom, $urandom}, 8'($urandom & $urandom), 8'($urandom & $urandom),
                 8'($urandom & $urandom & $urandom), 1'($urandom_range(0, 1)), "R3");
        end
        drain("R3");
        chk("R1", rbuf_word, 16'h0000);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule